// File: doc/BRIEF.md
# Handshaked Serial-Network Slave Node

This block is a slave node on a shared serial network run by a host controller. The host links to every node with a chip-select style serial link: an active-low select, a serial clock, a data line from host to node and a data line from node to host. Two extra wires set the pace. The host raises a message strobe to open a message. The node drives a single acknowledge line that does two jobs. It confirms each byte the node has taken in. It also tells the host that the node has a byte waiting to be read.

A message begins with a long strobe lead-in. The first byte is the address byte. Its low five bits name the target node, and the node compares them with its own identifier. Identifiers 0 to 23 are reserved; 24 to 31 are free for user nodes.

- On a match, the node forwards each following byte to a local consumer over a valid/ready interface.
- A local producer can hand the node one byte to return. The node announces that byte with an acknowledge pulse, and the host's next byte transfer carries it out on the return line.
- Any abnormal end of a transfer sends the node back to idle.

Top module: `net_slave_node`

## Requirements
- R1: Bits on `net_mosi` are captured on rising edges of `net_sck` while `net_sel_n` is low, most-significant bit first. A payload byte reaches `rx_data` unchanged.
- R2: `net_miso` changes only after falling edges of `net_sck` and sends most-significant bit first. During a transfer that follows an announcement it carries the announced byte. During any other transfer it carries 0x00.
- R3: A rising edge of `net_strobe` starts a lead-in of `LEAD_US*TICK_DIV` clock cycles. Serial clock edges during the lead-in are ignored and produce no acknowledge.
- R4: The first byte after the lead-in is an address byte. If its bits [4:0] equal `node_id` it is acknowledged. Bits [7:5] are don't-care. The address byte never appears on `rx_data`.
- R5: If the address does not match, the node gives no acknowledge and no `rx_valid` for the rest of the message. It takes part again only after `net_strobe` falls and rises again.
- R6: Every acknowledge pulse on `net_ack` is high for exactly `ACK_US*TICK_DIV` clock cycles.
- R7: When a payload byte completes while `rx_valid` is high, its acknowledge is held back. Once the consumer takes the earlier byte, the new byte is put on `rx_data` and acknowledged.
- R8: After a byte is accepted on `tx_data`/`tx_valid`, `tx_ready` falls and the node gives an announce pulse on `net_ack`. The next byte transfer is a read: it is not forwarded and not acknowledged, and `tx_ready` rises after it.
- R9: The message is aborted if `net_sel_n` rises in the middle of a byte, or if `net_strobe` falls at any point. The partial byte is discarded. Later bytes are ignored until a new strobe rising edge.
- R10: After reset, `net_ack` is 0, `rx_valid` is 0, `tx_ready` is 1 and `net_miso` is 0.
- R11: While `rx_valid` is high and `rx_ready` is low, `rx_valid` stays high and `rx_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| node_id | input | 5 | Identifier of this node |
| net_sel_n | input | 1 | Network select from host, active low |
| net_sck | input | 1 | Serial clock from host |
| net_mosi | input | 1 | Serial data, host to node |
| net_strobe | input | 1 | Message strobe from host, active high |
| net_miso | output | 1 | Serial data, node to host |
| net_ack | output | 1 | Acknowledge and byte-ready pulse line |
| rx_data | output | 8 | Received payload byte |
| rx_valid | output | 1 | Payload byte present |
| rx_ready | input | 1 | Consumer takes the payload byte |
| tx_data | input | 8 | Byte to return to the host |
| tx_valid | input | 1 | Producer offers a byte |
| tx_ready | output | 1 | Node can accept a return byte |

## Verification
The hardest case to reach from the ports is a completed payload byte that arrives while the receive buffer is still full. To get there, the bench leaves `rx_ready` low across two payload transfers. It then confirms that no acknowledge appears and that the first byte stays in place before it releases the consumer. A second hard case is the read transfer after an announcement. Its incoming bits must be thrown away while its outgoing bits carry the stored byte. The bench reaches it by offering a return byte in the middle of an open message, waiting for the announce pulse and then clocking one full transfer.

// File: rtl/net_node_pkg.sv
// Shared types and widths for the serial-network slave node.
// Assumes: bytes are eight bits and identifiers five bits across the network.
package net_node_pkg;
    localparam int BYTE_W = 8;
    localparam int ID_W   = 5;

    // Message-level states of the node
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a strobe rising edge
        ST_LEAD,   // strobe lead-in running
        ST_ADDR,   // expecting the address byte
        ST_OPEN,   // addressed, exchanging bytes
        ST_HOLD,   // finished byte waits for a free buffer
        ST_SKIP    // message addressed elsewhere
    } node_state_t;
endpackage

// File: rtl/net_sync.sv
// Two-flop synchroniser for a bundle of asynchronous single-bit inputs.
// Assumes: each bit is independent; reset value is given per bit.
module net_sync #(
    parameter int           W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] meta;

    // Two register stages per bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta  <= RST_VAL;
            d_out <= RST_VAL;
        end else begin
            meta  <= d_in;
            d_out <= meta;
        end
    end
endmodule

// File: rtl/net_oneshot.sv
// One-shot timer: after start, busy stays high for UNITS*TICK_DIV cycles.
// The prescaler divides the system clock into time units.
// Assumes: start restarts the timer; clr stops it at once.
module net_oneshot #(
    parameter int TICK_DIV = 50,
    parameter int UNITS    = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic clr,
    output logic busy
);
    localparam int PW = $clog2(TICK_DIV + 1);
    localparam int UW = $clog2(UNITS + 1);

    logic [PW-1:0] presc;
    logic [UW-1:0] units;

    // Prescaler and unit counter for one timed interval
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            presc <= '0;
            units <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            presc <= '0;
            units <= '0;
        end else if (clr) begin
            busy  <= 1'b0;
        end else if (busy) begin
            if (presc == PW'(TICK_DIV - 1)) begin
                presc <= '0;
                if (units == UW'(UNITS - 1)) busy <= 1'b0;
                else                         units <= units + 1'b1;
            end else begin
                presc <= presc + 1'b1;
            end
        end
    end
endmodule

// File: rtl/net_shift.sv
// Serial shifter: captures the host line on SCK rise and moves the return
// line on SCK fall, MSB first. Flags each completed byte for one cycle.
// Assumes: SCK idles low and is already synchronised; load only between bytes.
module net_shift
    import net_node_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              sck_s,
    input  logic              sel_act,
    input  logic              mosi_s,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_data,
    output logic              byte_done,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              mid_byte,
    output logic              miso
);
    localparam int CW = $clog2(BYTE_W);

    logic              sck_q;
    logic [CW-1:0]     bitcnt;
    logic [BYTE_W-1:0] rxsh;
    logic [BYTE_W-1:0] txsh;
    logic              sck_rise, sck_fall;

    assign sck_rise = sck_s && !sck_q;
    assign sck_fall = !sck_s && sck_q;
    assign mid_byte = (bitcnt != '0);
    assign miso     = txsh[BYTE_W-1];

    // Edge-delayed copy of the synchronised clock
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    // Shift both directions and close a byte after the last capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bitcnt    <= '0;
            rxsh      <= '0;
            txsh      <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            if (!en) begin
                bitcnt <= '0;
                txsh   <= '0;
            end else if (load) begin
                txsh <= load_data;
            end else if (sel_act && sck_rise) begin
                rxsh <= {rxsh[BYTE_W-2:0], mosi_s};
                if (bitcnt == CW'(BYTE_W - 1)) begin
                    bitcnt    <= '0;
                    rx_byte   <= {rxsh[BYTE_W-2:0], mosi_s};
                    byte_done <= 1'b1;
                    txsh      <= '0;
                end else begin
                    bitcnt <= bitcnt + 1'b1;
                end
            end else if (sel_act && sck_fall && mid_byte) begin
                txsh <= {txsh[BYTE_W-2:0], 1'b0};
            end
        end
    end
endmodule

// File: rtl/net_slave_node.sv
// Slave node of a strobe/acknowledge paced serial network.
// Sequences the lead-in, address match, payload delivery with a one-entry
// buffer, and announcement plus read-out of one return byte.
// Assumes: the host waits for each acknowledge before the next byte.
module net_slave_node
    import net_node_pkg::*;
#(
    parameter int TICK_DIV = 50,
    parameter int ACK_US   = 10,
    parameter int LEAD_US  = 500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   node_id,
    input  logic              net_sel_n,
    input  logic              net_sck,
    input  logic              net_mosi,
    input  logic              net_strobe,
    output logic              net_miso,
    output logic              net_ack,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_valid,
    input  logic              rx_ready,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready
);
    node_state_t       state;
    logic [3:0]        syn;
    logic              strobe_s, sel_act, sck_s, mosi_s, strobe_q;
    logic              lead_start, lead_busy, ack_start, ack_busy;
    logic              abort, shift_en, load, rx_write, buf_free;
    logic              byte_done, mid_byte, reading, tx_full;
    logic [BYTE_W-1:0] rx_byte, tx_hold;

    net_sync #(.W(4), .RST_VAL(4'b0100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d_in({net_strobe, net_sel_n, net_sck, net_mosi}), .d_out(syn)
    );
    assign strobe_s = syn[3];
    assign sel_act  = !syn[2];
    assign sck_s    = syn[1];
    assign mosi_s   = syn[0];

    net_oneshot #(.TICK_DIV(TICK_DIV), .UNITS(LEAD_US)) u_lead (
        .clk(clk), .rst_n(rst_n), .start(lead_start), .clr(!strobe_s), .busy(lead_busy)
    );
    net_oneshot #(.TICK_DIV(TICK_DIV), .UNITS(ACK_US)) u_ack (
        .clk(clk), .rst_n(rst_n), .start(ack_start), .clr(1'b0), .busy(ack_busy)
    );

    assign shift_en = (state == ST_ADDR) || (state == ST_OPEN) || (state == ST_SKIP);

    net_shift u_shift (
        .clk(clk), .rst_n(rst_n), .en(shift_en), .sck_s(sck_s), .sel_act(sel_act),
        .mosi_s(mosi_s), .load(load), .load_data(tx_hold), .byte_done(byte_done),
        .rx_byte(rx_byte), .mid_byte(mid_byte), .miso(net_miso)
    );

    assign net_ack  = ack_busy;
    assign tx_ready = !tx_full;
    assign buf_free = !rx_valid;

    // Decide acknowledges, announce loads and buffer writes for this cycle
    always_comb begin
        lead_start = (state == ST_IDLE) && strobe_s && !strobe_q;
        abort      = (state != ST_IDLE) && (!strobe_s || (mid_byte && !sel_act));
        ack_start  = 1'b0;
        load       = 1'b0;
        rx_write   = 1'b0;
        if (!abort) begin
            case (state)
                ST_ADDR: ack_start = byte_done && (rx_byte[ID_W-1:0] == node_id);
                ST_OPEN: begin
                    if (byte_done) begin
                        if (!reading && buf_free) begin
                            ack_start = 1'b1;
                            rx_write  = 1'b1;
                        end
                    end else if (tx_full && !reading && !ack_busy && !mid_byte) begin
                        ack_start = 1'b1;
                        load      = 1'b1;
                    end
                end
                ST_HOLD: begin
                    ack_start = buf_free;
                    rx_write  = buf_free;
                end
                default: ;
            endcase
        end
    end

    // Strobe history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe_s;
    end

    // Message state machine and read-transfer flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            reading <= 1'b0;
        end else if (abort) begin
            state   <= ST_IDLE;
            reading <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (lead_start) state <= ST_LEAD;
                ST_LEAD: if (!lead_busy) state <= ST_ADDR;
                ST_ADDR: if (byte_done)
                    state <= (rx_byte[ID_W-1:0] == node_id) ? ST_OPEN : ST_SKIP;
                ST_OPEN: begin
                    if (byte_done) begin
                        if (reading)        reading <= 1'b0;
                        else if (!buf_free) state   <= ST_HOLD;
                    end else if (load) begin
                        reading <= 1'b1;
                    end
                end
                ST_HOLD: if (buf_free) state <= ST_OPEN;
                default: ;
            endcase
        end
    end

    // One-entry receive buffer towards the consumer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else if (rx_write) begin
            rx_data  <= rx_byte;
            rx_valid <= 1'b1;
        end else if (rx_valid && rx_ready) begin
            rx_valid <= 1'b0;
        end
    end

    // Return-byte holding register, emptied by a completed read transfer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_hold <= '0;
            tx_full <= 1'b0;
        end else if (tx_valid && !tx_full) begin
            tx_hold <= tx_data;
            tx_full <= 1'b1;
        end else if (!abort && state == ST_OPEN && byte_done && reading) begin
            tx_full <= 1'b0;
        end
    end
endmodule

// File: rtl/net_slave_node_chk.sv
// Property checker for net_slave_node, bound into every instance.
// Assumes: ACK_CYC equals the configured acknowledge width in cycles.
module net_slave_node_chk
    import net_node_pkg::*;
#(
    parameter int ACK_CYC = 500
) (
    input logic              clk,
    input logic              rst_n,
    input logic              net_ack,
    input logic              lead_busy,
    input logic              byte_done,
    input logic [BYTE_W-1:0] rx_data,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic              tx_ready
);
    int ack_len;

    // Length of the current acknowledge run
    always_ff @(posedge clk) begin
        if (!rst_n)       ack_len <= 0;
        else if (net_ack) ack_len <= ack_len + 1;
        else              ack_len <= 0;
    end

    a_r6_ack_width: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(net_ack) |-> (ack_len == ACK_CYC));

    a_r3_no_ack_in_leadin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(net_ack) |-> !lead_busy);

    a_r1_byte_flag_single: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);

    a_r11_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

    a_r8_tx_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);
endmodule

bind net_slave_node net_slave_node_chk #(.ACK_CYC(ACK_US * TICK_DIV)) u_chk (
    .clk(clk), .rst_n(rst_n), .net_ack(net_ack), .lead_busy(lead_busy),
    .byte_done(byte_done), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_ready(tx_ready)
);

// File: tb/net_slave_node_bench.sv
// Directed bench for net_slave_node: one task per scenario.
module net_slave_node_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TDIV  = 4;
    localparam int AUS   = 3;
    localparam int LUS   = 30;
    localparam int ACKW  = AUS * TDIV;
    localparam int LEADW = LUS * TDIV;
    localparam int HALF  = 6;
    localparam logic [4:0] MY_ID = 5'd26;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_n = 1'b1, sck = 1'b0, mosi = 1'b0, strobe = 1'b0;
    logic       miso, ack, rx_valid, rx_ready = 1'b0, tx_valid = 1'b0, tx_ready;
    logic [7:0] rx_data, tx_data = 8'h00;

    int checks = 0, fails = 0, pulses = 0, run = 0, last_w = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    net_slave_node #(.TICK_DIV(TDIV), .ACK_US(AUS), .LEAD_US(LUS)) u_net_slave_node (
        .clk(clk), .rst_n(rst_n), .node_id(MY_ID), .net_sel_n(sel_n), .net_sck(sck),
        .net_mosi(mosi), .net_strobe(strobe), .net_miso(miso), .net_ack(ack),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
    );

    // Count acknowledge pulses and remember the last width
    always @(negedge clk) begin
        if (ack) run++;
        else if (run > 0) begin
            pulses++;
            last_w = run;
            run = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Clock nbits of a byte, MSB first; returns what came back on MISO
    task automatic xfer(input logic [7:0] out, input int nbits, output logic [7:0] got);
        got = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            @(negedge clk);
            sck  = 1'b0;
            mosi = out[i];
            wait_cyc(HALF);
            got[i] = miso;
            sck = 1'b1;
            wait_cyc(HALF);
        end
        @(negedge clk);
        sck = 1'b0;
    endtask

    task automatic open_msg(input logic [7:0] addr);
        logic [7:0] d;
        strobe = 1'b1;
        wait_cyc(LEADW + 20);
        sel_n = 1'b0;
        xfer(addr, 8, d);
        wait_cyc(ACKW + 20);
    endtask

    task automatic close_msg();
        sel_n  = 1'b1;
        strobe = 1'b0;
        wait_cyc(10);
    endtask

    task automatic consume();
        @(negedge clk); rx_ready = 1'b1;
        @(negedge clk); rx_ready = 1'b0;
    endtask

    task automatic t_reset();
        chk(ack == 1'b0,      "R10 ack", int'(ack), 0);
        chk(rx_valid == 1'b0, "R10 rx_valid", int'(rx_valid), 0);
        chk(tx_ready == 1'b1, "R10 tx_ready", int'(tx_ready), 1);
        chk(miso == 1'b0,     "R10 miso", int'(miso), 0);
    endtask

    task automatic t_receive();
        int p;
        logic [7:0] d;
        p = pulses;
        open_msg(8'hFA);               // bits [4:0] = 26, upper bits set
        chk(pulses == p + 1, "R4 address ack", pulses - p, 1);
        chk(last_w == ACKW, "R6 ack width", last_w, ACKW);
        chk(rx_valid == 1'b0, "R4 address not forwarded", int'(rx_valid), 0);
        foreach (d[k]) ;
        xfer(8'hA5, 8, d);
        wait_cyc(ACKW + 20);
        chk(pulses == p + 2, "R6 payload ack", pulses - p, 2);
        chk(last_w == ACKW, "R6 payload ack width", last_w, ACKW);
        chk(rx_valid && rx_data == 8'hA5, "R1 payload A5", int'(rx_data), 8'hA5);
        chk(d == 8'h00, "R2 idle return zero", int'(d), 0);
        consume();
        xfer(8'h3C, 8, d);
        wait_cyc(ACKW + 20);
        chk(rx_valid && rx_data == 8'h3C, "R1 payload 3C", int'(rx_data), 8'h3C);
        consume();
    endtask

    task automatic t_hold();
        int p;
        logic [7:0] d;
        p = pulses;
        xfer(8'h11, 8, d);
        wait_cyc(ACKW + 20);
        chk(pulses == p + 1, "R7 first ack", pulses - p, 1);
        xfer(8'h22, 8, d);
        wait_cyc(ACKW + 30);
        chk(pulses == p + 1, "R7 ack withheld", pulses - p, 1);
        chk(rx_valid && rx_data == 8'h11, "R11 data held", int'(rx_data), 8'h11);
        consume();
        wait_cyc(ACKW + 20);
        chk(pulses == p + 2, "R7 late ack", pulses - p, 2);
        chk(rx_valid && rx_data == 8'h22, "R7 second byte", int'(rx_data), 8'h22);
        consume();
    endtask

    task automatic t_return();
        int p;
        logic [7:0] d;
        p = pulses;
        @(negedge clk); tx_data = 8'hC3; tx_valid = 1'b1;
        @(negedge clk); tx_valid = 1'b0;
        chk(tx_ready == 1'b0, "R8 tx_ready low", int'(tx_ready), 0);
        wait_cyc(ACKW + 20);
        chk(pulses == p + 1, "R8 announce pulse", pulses - p, 1);
        xfer(8'h5A, 8, d);
        chk(d == 8'hC3, "R2 read byte", int'(d), 8'hC3);
        wait_cyc(ACKW + 20);
        chk(pulses == p + 1, "R8 read not acked", pulses - p, 1);
        chk(rx_valid == 1'b0, "R8 read not forwarded", int'(rx_valid), 0);
        chk(tx_ready == 1'b1, "R8 tx_ready back", int'(tx_ready), 1);
        xfer(8'h01, 8, d);
        wait_cyc(ACKW + 20);
        chk(d == 8'h00, "R2 zero after read", int'(d), 0);
        consume();
        close_msg();
    endtask

    task automatic t_mismatch();
        int p;
        logic [7:0] d;
        p = pulses;
        open_msg(8'h19);               // identifier 25
        chk(pulses == p, "R5 no address ack", pulses - p, 0);
        xfer(8'h44, 8, d);
        wait_cyc(ACKW + 20);
        chk(pulses == p, "R5 payload ignored", pulses - p, 0);
        chk(rx_valid == 1'b0, "R5 nothing forwarded", int'(rx_valid), 0);
        close_msg();
        open_msg(8'h1A);
        chk(pulses == p + 1, "R5 next message accepted", pulses - p, 1);
        close_msg();
    endtask

    task automatic t_leadin();
        int p;
        logic [7:0] d;
        p = pulses;
        strobe = 1'b1;
        wait_cyc(4);
        sel_n = 1'b0;
        xfer(8'h1A, 8, d);             // completes inside the lead-in
        wait_cyc(ACKW + 20);
        chk(pulses == p, "R3 lead-in byte ignored", pulses - p, 0);
        xfer(8'h1A, 8, d);
        wait_cyc(ACKW + 20);
        chk(pulses == p + 1, "R3 address after lead-in", pulses - p, 1);
        close_msg();
    endtask

    task automatic t_abort();
        int p;
        logic [7:0] d;
        open_msg(8'h1A);
        p = pulses;
        xfer(8'hF0, 4, d);
        sel_n = 1'b1;
        wait_cyc(10);
        sel_n = 1'b0;
        xfer(8'h77, 8, d);
        wait_cyc(ACKW + 20);
        chk(pulses == p, "R9 select abort no ack", pulses - p, 0);
        chk(rx_valid == 1'b0, "R9 select abort no data", int'(rx_valid), 0);
        close_msg();
        open_msg(8'h1A);
        p = pulses;
        xfer(8'h0F, 3, d);
        strobe = 1'b0;
        wait_cyc(10);
        strobe = 1'b1;                 // no lead-in restart without release
        xfer(8'h66, 8, d);
        wait_cyc(ACKW + 20);
        chk(pulses == p, "R9 strobe abort no ack", pulses - p, 0);
        close_msg();
        p = pulses;
        open_msg(8'h1A);
        chk(pulses == p + 1, "R9 recovery", pulses - p, 1);
        close_msg();
    endtask

    initial begin
        wait_cyc(5);
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        wait_cyc(5);
        t_receive();
        t_hold();
        t_return();
        t_mismatch();
        t_leadin();
        t_abort();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule